// File: doc/BRIEF.md
# Detector Readout Pattern Sequencer

This block produces the timed control levels that drive an infrared focal-plane array and its external ADC, and it collects the conversion results. A host first fills a small program store while the block is idle. Each entry holds an 8-bit output level and a 2-bit action. A single start command then runs a complete scan. The sequencer walks the program once per sample and returns to entry 0 at each end-of-sample entry. The host plays no part between samples, so every sample in a scan runs with the same timing.

One program entry executes per clock. An entry can show its level for one cycle, hold it for a programmed settling time, or hold it until the ADC reports end-of-conversion. Each captured 17-bit result goes into a 32-entry first-word-fall-through queue, and the host drains that queue through a simple read strobe. If a conversion never completes, a timeout stores a marked sample and raises a sticky error. If the queue is full when a result is ready, the sequencer stalls rather than lose the result, and it raises a sticky warning.

Top module: `fpa_readout_seq`

## Requirements
- R1: After reset `pat_out` is 0. While idle, `pat_out` shows the level held in program entry 0, updated one cycle after the entry is written.
- R2: A program write stores `prog_data` at `prog_addr`. Bits [7:0] hold the level and bits [9:8] hold the action: 0 = step, 1 = settle, 2 = wait for conversion, 3 = end of sample. A write made while `busy` is high is ignored.
- R3: A step entry drives its level for exactly one cycle, and then the next address executes.
- R4: A settle entry drives its level for max(S,1) cycles, where S is the settle count latched at start.
- R5: A wait-for-conversion entry holds its level until `adc_eoc` is high. In that cycle it pushes {1'b0, `adc_data`} into the queue and moves to the next entry.
- R6: If `adc_eoc` has not been seen within max(T,1) cycles of a wait entry (T = latched timeout), the sequencer pushes {1'b1, 17'b0}, sets `timeout_err`, and moves on. `timeout_err` stays set until the next accepted start.
- R7: A capture or timeout push that finds the queue full stalls the sequencer on that entry and sets the sticky `ovf_warn`. The push completes once space is free, and no sample is lost.
- R8: An end-of-sample entry returns execution to entry 0. After L samples (L latched at start, with 0 treated as 1), `busy` falls and `done` rises in the same cycle, and `busy` and `done` are never both high.
- R9: A start pulse while idle sets `busy` and clears `done`, `timeout_err` and `ovf_warn` on the next cycle. A start pulse while `busy` is high has no effect.
- R10: The queue holds 32 entries and `fifo_rdata` shows the oldest one. `fifo_rd` removes that entry. A read of an empty queue does nothing, and `fifo_full` and `fifo_empty` are never both high.
- R11: The settle, timeout and scan-length inputs are sampled only when a start is accepted. Changing them during a scan has no effect on that scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one program entry per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program store write strobe |
| prog_addr | input | 8 | Program store write address |
| prog_data | input | 10 | Entry: action in [9:8], level in [7:0] |
| cfg_settle | input | 16 | Settle hold in cycles |
| cfg_timeout | input | 16 | Conversion timeout in cycles |
| cfg_scan_len | input | 16 | Samples per scan |
| start | input | 1 | Start a scan (accepted when idle) |
| pat_out | output | 8 | Control level to the array and ADC |
| adc_data | input | 17 | Conversion result |
| adc_eoc | input | 1 | End-of-conversion level |
| fifo_rd | input | 1 | Remove the oldest queued result |
| fifo_rdata | output | 18 | Oldest result: timeout marker in bit 17 |
| fifo_empty | output | 1 | Queue empty |
| fifo_full | output | 1 | Queue full |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Last scan completed |
| timeout_err | output | 1 | Sticky conversion-timeout flag |
| ovf_warn | output | 1 | Sticky queue-full stall flag |

## Verification
The properties assume that `start`, `fifo_rd` and the program inputs are synchronous to `clk`. They also assume that `adc_eoc`, once raised, stays high while the convert level is shown, so that a stalled capture can still complete. The bench's ADC responder raises `adc_eoc` a programmed number of cycles after bit 7 of `pat_out` rises and holds it until bit 7 falls. The bench drives every input a fixed delay after the rising edge. A very long responder delay produces timeouts, and withholding reads produces queue-full stalls.

// File: rtl/fpa_seq_pkg.sv
package fpa_seq_pkg;

   typedef enum logic [1:0] {
      OP_STEP   = 2'd0,
      OP_SETTLE = 2'd1,
      OP_CONV   = 2'd2,
      OP_EOS    = 2'd3
   } seq_op_e;

   localparam int unsigned OP_W = 2;

endpackage

// File: rtl/fpa_seq_pattern_ram.sv
module fpa_seq_pattern_ram #(
   parameter int unsigned AW  = 8,
   parameter int unsigned EW  = 10,
   parameter int unsigned NRD = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [EW-1:0]            wdata,
   input  logic [NRD-1:0][AW-1:0]   raddr,
   output logic [NRD-1:0][EW-1:0]   rdata
);

   localparam int unsigned DEPTH = 1 << AW;

   if (NRD < 1) begin : g_bad_nrd
      $error("fpa_seq_pattern_ram: NRD must be at least 1");
   end

   logic [EW-1:0] store [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) store[i] <= '0;
      end else if (we) begin
         store[waddr] <= wdata;
      end
   end

   for (genvar p = 0; p < NRD; p++) begin : g_rd
      assign rdata[p] = store[raddr[p]];
   end

endmodule

// File: rtl/fpa_seq_fifo.sv
module fpa_seq_fifo #(
   parameter int unsigned W     = 18,
   parameter int unsigned DEPTH = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] push_data,
   input  logic         pop,
   output logic [W-1:0] head,
   output logic         empty,
   output logic         full
);

   localparam int unsigned PW    = $clog2(DEPTH);
   localparam int unsigned CW    = PW + 1;
   localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
   localparam logic [PW-1:0] LAST     = PW'(DEPTH - 1);
   localparam bit POW2 = ((1 << PW) == DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("fpa_seq_fifo: DEPTH must be at least 2");
   end

   logic [W-1:0]  slots [DEPTH];
   logic [PW-1:0] wp, rp, wp_nxt, rp_nxt;
   logic [CW-1:0] count;
   logic          do_push, do_pop;

   assign empty   = (count == '0);
   assign full    = (count == FULL_CNT);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign head    = slots[rp];

   if (POW2) begin : g_wrap_pow2
      assign wp_nxt = wp + 1'b1;
      assign rp_nxt = rp + 1'b1;
   end else begin : g_wrap_cmp
      assign wp_nxt = (wp == LAST) ? '0 : wp + 1'b1;
      assign rp_nxt = (rp == LAST) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (do_push) slots[wp] <= push_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (do_push) wp <= wp_nxt;
         if (do_pop)  rp <= rp_nxt;
         case ({do_push, do_pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/fpa_seq_ctrl.sv
module fpa_seq_ctrl
   import fpa_seq_pkg::*;
#(
   parameter int unsigned AW    = 8,
   parameter int unsigned PAT_W = 8,
   parameter int unsigned DW    = 17,
   parameter int unsigned CW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CW-1:0]    cfg_settle,
   input  logic [CW-1:0]    cfg_timeout,
   input  logic [CW-1:0]    cfg_scan_len,
   input  seq_op_e          cur_op,
   input  logic [PAT_W-1:0] nxt_pat,
   output logic [AW-1:0]    cur_addr,
   output logic [AW-1:0]    nxt_addr,
   input  logic [DW-1:0]    adc_data,
   input  logic             adc_eoc,
   input  logic             fifo_full,
   output logic             push,
   output logic [DW:0]      push_data,
   output logic [PAT_W-1:0] pat_out,
   output logic             busy,
   output logic             done,
   output logic             timeout_err,
   output logic             ovf_warn
);

   logic [AW-1:0] pc;
   logic [CW-1:0] wcnt, smp_cnt;
   logic [CW-1:0] settle_q, tmo_q, len_q;
   logic [CW:0]   wcnt_inc, smp_inc;
   logic          adv, wrap, fin, stall, tmo_hit;

   assign wcnt_inc = {1'b0, wcnt} + 1'b1;
   assign smp_inc  = {1'b0, smp_cnt} + 1'b1;
   assign cur_addr = pc;
   assign nxt_addr = (!busy || wrap) ? '0 : pc + 1'b1;

   always_comb begin
      adv       = 1'b0;
      wrap      = 1'b0;
      fin       = 1'b0;
      stall     = 1'b0;
      tmo_hit   = 1'b0;
      push      = 1'b0;
      push_data = '0;
      if (busy) begin
         unique case (cur_op)
            OP_STEP: adv = 1'b1;
            OP_SETTLE: adv = (wcnt_inc >= {1'b0, settle_q});
            OP_CONV: begin
               if (adc_eoc) begin
                  if (fifo_full) stall = 1'b1;
                  else begin
                     push      = 1'b1;
                     push_data = {1'b0, adc_data};
                     adv       = 1'b1;
                  end
               end else if (wcnt_inc >= {1'b0, tmo_q}) begin
                  if (fifo_full) stall = 1'b1;
                  else begin
                     push      = 1'b1;
                     push_data = {1'b1, {DW{1'b0}}};
                     tmo_hit   = 1'b1;
                     adv       = 1'b1;
                  end
               end
            end
            OP_EOS: begin
               wrap = 1'b1;
               fin  = (smp_inc >= {1'b0, len_q});
            end
            default: adv = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pc          <= '0;
         wcnt        <= '0;
         smp_cnt     <= '0;
         settle_q    <= '0;
         tmo_q       <= '0;
         len_q       <= '0;
         pat_out     <= '0;
         busy        <= 1'b0;
         done        <= 1'b0;
         timeout_err <= 1'b0;
         ovf_warn    <= 1'b0;
      end else if (!busy) begin
         pat_out <= nxt_pat;
         if (start) begin
            busy        <= 1'b1;
            pc          <= '0;
            wcnt        <= '0;
            smp_cnt     <= '0;
            done        <= 1'b0;
            timeout_err <= 1'b0;
            ovf_warn    <= 1'b0;
            settle_q    <= cfg_settle;
            tmo_q       <= cfg_timeout;
            len_q       <= cfg_scan_len;
         end
      end else begin
         if (stall)   ovf_warn    <= 1'b1;
         if (tmo_hit) timeout_err <= 1'b1;
         if (adv) begin
            pc      <= nxt_addr;
            pat_out <= nxt_pat;
            wcnt    <= '0;
         end else if (wrap) begin
            pc      <= '0;
            pat_out <= nxt_pat;
            wcnt    <= '0;
            if (fin) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               smp_cnt <= smp_cnt + 1'b1;
            end
         end else if (!stall) begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

endmodule

// File: rtl/fpa_readout_seq.sv
module fpa_readout_seq
   import fpa_seq_pkg::*;
#(
   parameter int unsigned AW         = 8,
   parameter int unsigned PAT_W      = 8,
   parameter int unsigned DW         = 17,
   parameter int unsigned CW         = 16,
   parameter int unsigned FIFO_DEPTH = 32
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  prog_we,
   input  logic [AW-1:0]         prog_addr,
   input  logic [PAT_W+OP_W-1:0] prog_data,
   input  logic [CW-1:0]         cfg_settle,
   input  logic [CW-1:0]         cfg_timeout,
   input  logic [CW-1:0]         cfg_scan_len,
   input  logic                  start,
   output logic [PAT_W-1:0]      pat_out,
   input  logic [DW-1:0]         adc_data,
   input  logic                  adc_eoc,
   input  logic                  fifo_rd,
   output logic [DW:0]           fifo_rdata,
   output logic                  fifo_empty,
   output logic                  fifo_full,
   output logic                  busy,
   output logic                  done,
   output logic                  timeout_err,
   output logic                  ovf_warn
);

   localparam int unsigned EW = PAT_W + OP_W;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("fpa_readout_seq: AW out of range");
   end
   if (PAT_W < 1) begin : g_bad_patw
      $error("fpa_readout_seq: PAT_W must be positive");
   end
   if (CW < 2) begin : g_bad_cw
      $error("fpa_readout_seq: CW must be at least 2");
   end

   logic [1:0][AW-1:0] rd_addr;
   logic [1:0][EW-1:0] rd_word;
   logic [AW-1:0]      cur_addr, nxt_addr;
   logic               push;
   logic [DW:0]        push_data;
   seq_op_e            cur_op;

   assign rd_addr = {nxt_addr, cur_addr};
   assign cur_op  = seq_op_e'(rd_word[0][EW-1 -: OP_W]);

   fpa_seq_pattern_ram #(.AW(AW), .EW(EW), .NRD(2)) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (prog_we && !busy),
      .waddr (prog_addr),
      .wdata (prog_data),
      .raddr (rd_addr),
      .rdata (rd_word)
   );

   fpa_seq_ctrl #(.AW(AW), .PAT_W(PAT_W), .DW(DW), .CW(CW)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .start        (start),
      .cfg_settle   (cfg_settle),
      .cfg_timeout  (cfg_timeout),
      .cfg_scan_len (cfg_scan_len),
      .cur_op       (cur_op),
      .nxt_pat      (rd_word[1][PAT_W-1:0]),
      .cur_addr     (cur_addr),
      .nxt_addr     (nxt_addr),
      .adc_data     (adc_data),
      .adc_eoc      (adc_eoc),
      .fifo_full    (fifo_full),
      .push         (push),
      .push_data    (push_data),
      .pat_out      (pat_out),
      .busy         (busy),
      .done         (done),
      .timeout_err  (timeout_err),
      .ovf_warn     (ovf_warn)
   );

   fpa_seq_fifo #(.W(DW + 1), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .push_data (push_data),
      .pop       (fifo_rd),
      .head      (fifo_rdata),
      .empty     (fifo_empty),
      .full      (fifo_full)
   );

endmodule

// File: rtl/fpa_readout_seq_chk.sv
module fpa_readout_seq_chk (
   input logic clk,
   input logic rst_n,
   input logic start,
   input logic fifo_rd,
   input logic fifo_empty,
   input logic fifo_full,
   input logic busy,
   input logic done,
   input logic timeout_err,
   input logic ovf_warn
);

   p_busy_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !done);

   p_done_holds_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && start) |=> (busy && !done && !timeout_err && !ovf_warn));

   p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (timeout_err && !(start && !busy)) |=> timeout_err);

   p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_warn && !(start && !busy)) |=> ovf_warn);

   p_full_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_full && !fifo_rd) |=> fifo_full);

   p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_full && fifo_empty));

   p_idle_no_push_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_empty && !busy) |=> fifo_empty);

endmodule

bind fpa_readout_seq fpa_readout_seq_chk u_chk (.*);

// File: tb/tb_fpa_readout_seq.sv
module tb_fpa_readout_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        prog_we = 1'b0;
   logic [7:0]  prog_addr = '0;
   logic [9:0]  prog_data = '0;
   logic [15:0] cfg_settle = '0, cfg_timeout = '0, cfg_scan_len = '0;
   logic        start = 1'b0;
   logic [7:0]  pat_out;
   logic [16:0] adc_data = 17'h10000;
   logic        adc_eoc = 1'b0;
   logic        fifo_rd = 1'b0;
   logic [17:0] fifo_rdata;
   logic        fifo_empty, fifo_full, busy, done, timeout_err, ovf_warn;

   int checks = 0, failures = 0, cyc = 0;
   int adc_delay = 3, conv = 0;

   always #5 clk = ~clk;

   fpa_readout_seq dut (.*);

   // ---------------- reference model ----------------
   int          m_op [256];
   int          m_pat[256];
   logic [17:0] m_q[$];
   int m_pc, m_w, m_cnt, m_set, m_tmo, m_len, m_pat_out;
   bit m_busy, m_done, m_err, m_ovf;

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_op[i]) begin m_op[i] = 0; m_pat[i] = 0; end
         m_q.delete();
         m_pc = 0; m_w = 0; m_cnt = 0; m_pat_out = 0;
         m_busy = 0; m_done = 0; m_err = 0; m_ovf = 0;
      end else begin
         bit full_pre, adv, wrap, stall, push;
         logic [17:0] pd;
         full_pre = (m_q.size() == 32);
         adv = 0; wrap = 0; stall = 0; push = 0; pd = '0;
         if (m_busy) begin
            case (m_op[m_pc])
               0: adv = 1;
               1: adv = (m_w + 1 >= m_set);
               2: begin
                  if (adc_eoc) begin
                     if (full_pre) stall = 1;
                     else begin push = 1; pd = {1'b0, adc_data}; adv = 1; end
                  end else if (m_w + 1 >= m_tmo) begin
                     if (full_pre) stall = 1;
                     else begin push = 1; pd = {1'b1, 17'h0}; adv = 1; m_err = 1; end
                  end
               end
               default: wrap = 1;
            endcase
         end
         if (fifo_rd && m_q.size() > 0) void'(m_q.pop_front());
         if (push) m_q.push_back(pd);
         if (!m_busy) begin
            m_pat_out = m_pat[0];
            if (start) begin
               m_busy = 1; m_pc = 0; m_w = 0; m_cnt = 0;
               m_done = 0; m_err = 0; m_ovf = 0;
               m_set = cfg_settle; m_tmo = cfg_timeout; m_len = cfg_scan_len;
            end
            if (prog_we) begin
               m_op[prog_addr]  = prog_data[9:8];
               m_pat[prog_addr] = prog_data[7:0];
            end
         end else begin
            if (stall) m_ovf = 1;
            if (adv) begin
               m_pc = (m_pc + 1) % 256; m_pat_out = m_pat[m_pc]; m_w = 0;
            end else if (wrap) begin
               m_pc = 0; m_pat_out = m_pat[0]; m_w = 0;
               if (m_cnt + 1 >= m_len) begin m_busy = 0; m_done = 1; end
               else m_cnt++;
            end else if (!stall) m_w++;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R1/R3/R4/R11 pat_out", 32'(pat_out), 32'(m_pat_out));
         chk("R8 busy", 32'(busy), 32'(m_busy));
         chk("R8/R9 done", 32'(done), 32'(m_done));
         chk("R6 timeout_err", 32'(timeout_err), 32'(m_err));
         chk("R7 ovf_warn", 32'(ovf_warn), 32'(m_ovf));
         chk("R10 fifo_empty", 32'(fifo_empty), 32'(m_q.size() == 0));
         chk("R10 fifo_full", 32'(fifo_full), 32'(m_q.size() == 32));
         if (m_q.size() > 0) chk("R5/R6 fifo_rdata", 32'(fifo_rdata), 32'(m_q[0]));
      end
   end

   // ADC responder: convert level is pat_out bit 7
   always @(posedge clk) begin
      #2;
      if (pat_out[7]) begin
         conv++;
         if (conv >= adc_delay) adc_eoc = 1'b1;
      end else begin
         if (adc_eoc) adc_data = adc_data + 17'd1;
         conv = 0;
         adc_eoc = 1'b0;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         failures++;
         $display("FAIL R8 watchdog actual=%0d expected<=%0d", cyc, 100000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic wr(input int a, input int op, input int pat);
      prog_addr = 8'(a); prog_data = {2'(op), 8'(pat)}; prog_we = 1'b1;
      step(1);
      prog_we = 1'b0;
   endtask

   task automatic go(input int len, input int st, input int tmo);
      cfg_scan_len = 16'(len); cfg_settle = 16'(st); cfg_timeout = 16'(tmo);
      start = 1'b1;
      step(1);
      start = 1'b0;
   endtask

   task automatic drain(output int n, output int nerr);
      n = 0; nerr = 0;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (done && fifo_empty && !busy) break;
         if (!fifo_empty) begin
            n++;
            if (fifo_rdata[17]) nerr++;
            @(posedge clk); #2 fifo_rd = 1'b1;
            @(posedge clk); #2 fifo_rd = 1'b0;
         end
      end
   endtask

   initial begin
      int n, ne;
      step(2);
      // R1: reset state
      @(negedge clk);
      chk("R1 reset pat_out", 32'(pat_out), 0);
      chk("R8 reset busy", 32'(busy), 0);
      chk("R10 reset empty", 32'(fifo_empty), 1);
      step(0);
      rst_n = 1'b1;
      step(1);
      // R2: program layout, action in [9:8], level in [7:0]
      wr(0, 0, 8'h01);
      wr(1, 1, 8'h02);
      wr(2, 2, 8'h82);
      wr(3, 0, 8'h04);
      wr(4, 3, 8'h00);
      step(1);
      @(negedge clk);
      chk("R1 idle shows entry 0", 32'(pat_out), 32'h01);
      step(0);

      // R3 R4 R5: normal scan with reads running concurrently
      adc_delay = 3;
      go(3, 5, 50);
      drain(n, ne);
      chk("R8 sample count", 32'(n), 3);
      chk("R5 no error marks", 32'(ne), 0);
      chk("R8 done set", 32'(done), 1);

      // R10: read of empty queue ignored
      fifo_rd = 1'b1; step(3); fifo_rd = 1'b0; step(1);
      @(negedge clk);
      chk("R10 empty after empty reads", 32'(fifo_empty), 1);
      chk("R10 not full", 32'(fifo_full), 0);

      // R6: conversion timeout
      adc_delay = 1000;
      go(2, 1, 7);
      drain(n, ne);
      chk("R6 timeout samples", 32'(n), 2);
      chk("R6 all marked", 32'(ne), 2);
      chk("R6 sticky flag", 32'(timeout_err), 1);

      // R7 R9: queue full stall, start clears flags
      adc_delay = 2;
      go(34, 1, 40);
      @(negedge clk);
      chk("R9 err cleared", 32'(timeout_err), 0);
      for (int i = 0; i < 3000 && !ovf_warn; i++) step(1);
      @(negedge clk);
      chk("R7 warn raised", 32'(ovf_warn), 1);
      chk("R7 full while stalled", 32'(fifo_full), 1);
      chk("R7 still busy", 32'(busy), 1);
      drain(n, ne);
      chk("R7 no sample lost", 32'(n), 34);

      // R2 R9 R11: writes, restarts and config changes during a scan
      adc_delay = 3;
      go(3, 4, 50);
      step(2);
      wr(0, 0, 8'h55);
      cfg_scan_len = 16'd9; cfg_settle = 16'd1;
      start = 1'b1; step(1); start = 1'b0;
      drain(n, ne);
      chk("R11 scan length kept", 32'(n), 3);
      step(2);
      @(negedge clk);
      chk("R2 busy write ignored", 32'(pat_out), 32'h01);

      // R8 R4: zero length acts as one, zero settle holds one cycle
      go(0, 0, 50);
      drain(n, ne);
      chk("R8 zero length", 32'(n), 1);

      step(3);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule